// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the memory address of a load or store from up to three contributions. The first is an optional base register. The second is an optional index register multiplied by 1, 2, 4 or 8. The third is a signed 32-bit displacement. A segment base, chosen by a three-bit segment selector from a six-entry table, is added to the sum. The block fetches its two register operands through two combinational read ports. These ports go to a 16-entry general register file that sits outside the block. The 64-bit result leaves through a registered valid/ready output stage.

Some operand combinations are rejected. An index field that names the stack pointer (register 4) is illegal. A scale other than one with no index present is also illegal. The block flags these forms and drives the address to zero. A reference made only of a base register, or only of a displacement, is legal. The segment-base table clears to zero on reset, which gives a flat address space. A separate configuration write port can reload any table entry.

Top module: `eag_unit`

## Requirements
- R1: For a legal request, out_addr equals segment base + base operand + scaled index + displacement, taken modulo 2^64. An operand whose enable is low contributes zero.
- R2: The scale field encodes the index multiplier as 2'b00 = 1, 2'b01 = 2, 2'b10 = 4 and 2'b11 = 8. The multiplication is a left shift of the index value by 0 to 3 bits.
- R3: The 32-bit displacement is sign-extended to 64 bits before it is added. Bit 31 is its sign.
- R4: When the index enable is high and the index register number is 4, the request is illegal. out_illegal is then 1 and out_addr is 0.
- R5: When the index enable is low and the scale field is not 2'b00, the request is illegal. out_illegal is then 1 and out_addr is 0.
- R6: A request with only a base register, or with neither register, is legal as long as its scale field is 2'b00. out_illegal is then 0.
- R7: Segment selectors 0 to 5 add their table entry to the address. Selectors 6 and 7 add zero.
- R8: All six table entries are zero after reset. A configuration write with cfg_we high stores cfg_data into entry cfg_sel, and requests accepted from the next cycle on see the new value. Writes with cfg_sel of 6 or 7 change nothing.
- R9: A request is accepted on a rising edge when in_valid and in_ready are both high. Its result is presented with out_valid high on the following cycle. in_ready equals (not out_valid) or out_ready. This allows one address per cycle, and while out_ready is low the output is held unchanged.
- R10: While rst is high, out_valid goes low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| base_en | input | 1 | Base register is part of the address |
| base_reg | input | 4 | Base register number |
| idx_en | input | 1 | Index register is part of the address |
| idx_reg | input | 4 | Index register number |
| scale | input | 2 | Index multiplier code |
| disp | input | 32 | Signed displacement |
| seg_sel | input | 3 | Segment selector |
| rf_base_sel | output | 4 | Register file read address for the base |
| rf_base_data | input | 64 | Register file data for the base |
| rf_idx_sel | output | 4 | Register file read address for the index |
| rf_idx_data | input | 64 | Register file data for the index |
| cfg_we | input | 1 | Segment table write strobe |
| cfg_sel | input | 3 | Segment table entry to write |
| cfg_data | input | 64 | Segment base value to write |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Effective address |
| out_illegal | output | 1 | Request form is illegal |

## Verification
The assertions check the handshake on every cycle. They confirm the one-cycle latency, that the output holds while it is stalled, the relation between in_ready and out_valid, and that out_valid clears under reset. They also check that any flagged result carries a zero address and that a stack-pointer index is always flagged. Only the bench's scenarios can show the arithmetic itself: the shift amounts, the sign extension, the wraparound and the segment additions. The same holds for the effect of configuration writes, including writes to the unused selectors. The bench checks each of these against its own model over directed corners and a long back-to-back random stream.

// File: rtl/eag_pkg.sv
package eag_pkg;

    parameter int unsigned ADDR_W    = 64;
    parameter int unsigned DISP_W    = 32;
    parameter int unsigned NUM_REGS  = 16;
    parameter int unsigned NUM_SEGS  = 6;
    parameter int unsigned STACK_REG = 4;
    parameter int unsigned SEG_SEL_W = 3;

    localparam int unsigned REG_IDX_W = $clog2(NUM_REGS);
    localparam int unsigned EXT_W     = ADDR_W - DISP_W;

    typedef logic [ADDR_W-1:0]    addr_t;
    typedef logic [DISP_W-1:0]    disp_t;
    typedef logic [REG_IDX_W-1:0] reg_idx_t;
    typedef logic [SEG_SEL_W-1:0] seg_sel_t;

    typedef enum logic [1:0] {
        SCALE_X1 = 2'b00,
        SCALE_X2 = 2'b01,
        SCALE_X4 = 2'b10,
        SCALE_X8 = 2'b11
    } scale_e;

    typedef struct packed {
        logic     base_en;
        reg_idx_t base_reg;
        logic     idx_en;
        reg_idx_t idx_reg;
        scale_e   scale;
        disp_t    disp;
        seg_sel_t seg;
    } ea_req_t;

    typedef struct packed {
        addr_t addr;
        logic  illegal;
    } ea_rsp_t;

    function automatic addr_t widen_disp(input disp_t d);
        return {{EXT_W{d[DISP_W-1]}}, d};
    endfunction

    function automatic addr_t shift_index(input addr_t v, input scale_e s);
        addr_t r;
        case (s)
            SCALE_X1: r = v;
            SCALE_X2: r = {v[ADDR_W-2:0], 1'b0};
            SCALE_X4: r = {v[ADDR_W-3:0], 2'b00};
            default:  r = {v[ADDR_W-4:0], 3'b000};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/eag_form_check.sv
module eag_form_check
    import eag_pkg::*;
(
    input  logic     idx_en,
    input  reg_idx_t idx_reg,
    input  scale_e   scale,
    output logic     illegal
);
    localparam reg_idx_t SP_CODE = reg_idx_t'(STACK_REG);

    logic sp_as_index;
    logic orphan_scale;

    always_comb begin
        sp_as_index  = idx_en && (idx_reg == SP_CODE);
        orphan_scale = !idx_en && (scale != SCALE_X1);
        illegal      = sp_as_index || orphan_scale;
    end
endmodule

// File: rtl/eag_seg_table.sv
module eag_seg_table
    import eag_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  seg_sel_t wr_sel,
    input  addr_t    wr_data,
    input  seg_sel_t rd_sel,
    output addr_t    rd_base
);
    addr_t entry_q [NUM_SEGS];

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (wr_en && (wr_sel == seg_sel_t'(g))) begin
                entry_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_base = '0;
        for (int i = 0; i < NUM_SEGS; i++) begin
            if (rd_sel == seg_sel_t'(i)) begin
                rd_base = entry_q[i];
            end
        end
    end
endmodule

// File: rtl/eag_sum.sv
module eag_sum
    import eag_pkg::*;
(
    input  logic   base_en,
    input  addr_t  base_val,
    input  logic   idx_en,
    input  addr_t  idx_val,
    input  scale_e scale,
    input  disp_t  disp,
    input  addr_t  seg_base,
    output addr_t  sum
);
    addr_t base_term;
    addr_t idx_term;
    addr_t disp_term;

    always_comb begin
        base_term = base_en ? base_val : '0;
        idx_term  = idx_en ? shift_index(idx_val, scale) : '0;
        disp_term = widen_disp(disp);
        sum       = seg_base + base_term + idx_term + disp_term;
    end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 base_en,
    input  logic [REG_IDX_W-1:0] base_reg,
    input  logic                 idx_en,
    input  logic [REG_IDX_W-1:0] idx_reg,
    input  logic [1:0]           scale,
    input  logic [DISP_W-1:0]    disp,
    input  logic [SEG_SEL_W-1:0] seg_sel,
    output logic [REG_IDX_W-1:0] rf_base_sel,
    input  logic [ADDR_W-1:0]    rf_base_data,
    output logic [REG_IDX_W-1:0] rf_idx_sel,
    input  logic [ADDR_W-1:0]    rf_idx_data,
    input  logic                 cfg_we,
    input  logic [SEG_SEL_W-1:0] cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [ADDR_W-1:0]    out_addr,
    output logic                 out_illegal
);
    ea_req_t req;
    ea_rsp_t rsp_d;
    ea_rsp_t rsp_q;
    logic    valid_q;
    logic    accept;
    logic    bad_form;
    addr_t   seg_base;
    addr_t   raw_sum;

    always_comb begin
        req.base_en  = base_en;
        req.base_reg = base_reg;
        req.idx_en   = idx_en;
        req.idx_reg  = idx_reg;
        req.scale    = scale_e'(scale);
        req.disp     = disp;
        req.seg      = seg_sel;
    end

    assign rf_base_sel = req.base_reg;
    assign rf_idx_sel  = req.idx_reg;

    eag_form_check u_form (
        .idx_en  (req.idx_en),
        .idx_reg (req.idx_reg),
        .scale   (req.scale),
        .illegal (bad_form)
    );

    eag_seg_table u_segs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_data),
        .rd_sel  (req.seg),
        .rd_base (seg_base)
    );

    eag_sum u_sum (
        .base_en  (req.base_en),
        .base_val (rf_base_data),
        .idx_en   (req.idx_en),
        .idx_val  (rf_idx_data),
        .scale    (req.scale),
        .disp     (req.disp),
        .seg_base (seg_base),
        .sum      (raw_sum)
    );

    always_comb begin
        rsp_d.illegal = bad_form;
        rsp_d.addr    = bad_form ? '0 : raw_sum;
    end

    assign in_ready = !valid_q || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsp_q   <= '0;
        end else if (accept) begin
            valid_q <= 1'b1;
            rsp_q   <= rsp_d;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign out_valid   = valid_q;
    assign out_addr    = rsp_q.addr;
    assign out_illegal = rsp_q.illegal;
endmodule

// File: rtl/eag_unit_checker.sv
module eag_unit_checker
    import eag_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 idx_en,
    input logic [REG_IDX_W-1:0] idx_reg,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [ADDR_W-1:0]    out_addr,
    input logic                 out_illegal
);
    localparam logic [REG_IDX_W-1:0] SP_CODE = REG_IDX_W'(STACK_REG);

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_illegal)));

    p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    p_sp_index_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && idx_en && idx_reg == SP_CODE) |=> (out_illegal && out_addr == '0));

    p_flag_zero_addr_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_addr == '0));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

bind eag_unit eag_unit_checker u_eag_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .idx_en      (idx_en),
    .idx_reg     (idx_reg),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_addr    (out_addr),
    .out_illegal (out_illegal)
);

// File: tb/test_eag_unit.sv
`timescale 1ns/1ps
module test_eag_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready;
    logic        base_en, idx_en;
    logic [3:0]  base_reg, idx_reg;
    logic [1:0]  scale;
    logic [31:0] disp;
    logic [2:0]  seg_sel;
    logic [3:0]  rf_base_sel, rf_idx_sel;
    logic [63:0] rf_base_data, rf_idx_data;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [63:0] cfg_data;
    logic        out_valid, out_ready, out_illegal;
    logic [63:0] out_addr;

    logic [63:0] regs [16];
    logic [63:0] segm [8];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign rf_base_data = regs[rf_base_sel];
    assign rf_idx_data  = regs[rf_idx_sel];

    eag_unit i_eag_unit (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic model_bad(input logic ie, input logic [3:0] ir, input logic [1:0] sc);
        return (ie && ir == 4'd4) || (!ie && sc != 2'b00);
    endfunction

    function automatic logic [63:0] model_addr(input logic be, input logic [3:0] br,
        input logic ie, input logic [3:0] ir, input logic [1:0] sc,
        input logic [31:0] d, input logic [2:0] sg);
        logic [63:0] a;
        if (model_bad(ie, ir, sc)) return 64'd0;
        a = segm[sg] + {{32{d[31]}}, d};
        if (be) a = a + regs[br];
        if (ie) a = a + (regs[ir] << sc);
        return a;
    endfunction

    task automatic drive(input logic be, input logic [3:0] br, input logic ie,
        input logic [3:0] ir, input logic [1:0] sc, input logic [31:0] d, input logic [2:0] sg);
        base_en = be; base_reg = br; idx_en = ie; idx_reg = ir;
        scale = sc; disp = d; seg_sel = sg; in_valid = 1'b1;
    endtask

    // one request, result checked on the following negedge
    task automatic one(input string tag, input logic be, input logic [3:0] br, input logic ie,
        input logic [3:0] ir, input logic [1:0] sc, input logic [31:0] d, input logic [2:0] sg);
        @(negedge clk);
        drive(be, br, ie, ir, sc, d, sg);
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " valid"}, 64'(out_valid), 64'd1);
        chk({tag, " addr"}, out_addr, model_addr(be, br, ie, ir, sc, d, sg));
        chk({tag, " flag"}, 64'(out_illegal), 64'(model_bad(ie, ir, sc)));
    endtask

    task automatic cfg(input logic [2:0] s, input logic [63:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_data = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (s < 3'd6) segm[s] = v;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) regs[i] = {$urandom, $urandom};
        regs[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        regs[2] = 64'h0000_0000_0000_1000;
        regs[3] = 64'h0000_0000_0000_0011;
        for (int i = 0; i < 8; i++) segm[i] = 64'd0;
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; cfg_we = 1'b0;
        cfg_sel = 3'd0; cfg_data = 64'd0;
        drive(1'b0, 4'd0, 1'b0, 4'd0, 2'b00, 32'd0, 3'd0);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset out_valid", 64'(out_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 idle in_ready", 64'(in_ready), 64'd1);

        // R8 reset table is zero: segment 5 adds nothing
        one("R8 reset seg zero", 1'b1, 4'd2, 1'b0, 4'd0, 2'b00, 32'd4, 3'd5);
        one("R6 base only", 1'b1, 4'd2, 1'b0, 4'd0, 2'b00, 32'd0, 3'd0);
        one("R3 R6 disp only negative", 1'b0, 4'd0, 1'b0, 4'd0, 2'b00, 32'hFFFF_FFF0, 3'd0);
        one("R1 wrap", 1'b1, 4'd1, 1'b0, 4'd0, 2'b00, 32'd1, 3'd0);
        for (int s = 0; s < 4; s++)
            one("R2 scale", 1'b1, 4'd2, 1'b1, 4'd3, 2'(s), 32'd0, 3'd0);
        one("R4 sp index", 1'b1, 4'd2, 1'b1, 4'd4, 2'b00, 32'd8, 3'd0);
        one("R5 scale without index", 1'b1, 4'd2, 1'b0, 4'd3, 2'b10, 32'd8, 3'd0);

        cfg(3'd2, 64'h0000_1234_0000_0000);
        one("R7 R8 seg written", 1'b1, 4'd2, 1'b1, 4'd3, 2'b01, 32'h8000_0000, 3'd2);
        cfg(3'd6, 64'hDEAD_0000_0000_0000);
        cfg(3'd7, 64'hBEEF_0000_0000_0000);
        one("R7 R8 seg 6 zero", 1'b1, 4'd2, 1'b0, 4'd0, 2'b00, 32'd5, 3'd6);
        one("R7 R8 seg 7 zero", 1'b1, 4'd2, 1'b0, 4'd0, 2'b00, 32'd5, 3'd7);
        one("R8 seg 2 kept", 1'b0, 4'd0, 1'b0, 4'd0, 2'b00, 32'd0, 3'd2);

        // R9 backpressure
        @(negedge clk);
        out_ready = 1'b0;
        drive(1'b1, 4'd2, 1'b0, 4'd0, 2'b00, 32'd3, 3'd0);
        @(negedge clk);
        chk("R9 stall valid", 64'(out_valid), 64'd1);
        chk("R9 stall ready low", 64'(in_ready), 64'd0);
        drive(1'b1, 4'd3, 1'b0, 4'd0, 2'b00, 32'd7, 3'd0);
        @(negedge clk);
        chk("R9 stall hold", out_addr, 64'h1003);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 after stall", out_addr, 64'h18);
        @(negedge clk);
        chk("R9 drain", 64'(out_valid), 64'd0);

        // random back-to-back stream
        begin
            logic [63:0] pa; logic pb; bit have = 0;
            for (int n = 0; n < 400; n++) begin
                logic be, ie; logic [3:0] br, ir; logic [1:0] sc; logic [31:0] d; logic [2:0] sg;
                @(negedge clk);
                if (have) begin
                    chk("R9 stream valid", 64'(out_valid), 64'd1);
                    chk("R1 stream addr", out_addr, pa);
                    chk("R4 R5 stream flag", 64'(out_illegal), 64'(pb));
                end
                be = 1'($urandom); ie = ($urandom % 4) != 0;
                br = 4'($urandom); ir = 4'($urandom);
                sc = ie ? 2'($urandom) : (($urandom % 4) == 0 ? 2'($urandom) : 2'b00);
                d = $urandom; sg = 3'($urandom);
                drive(be, br, ie, ir, sc, d, sg);
                pa = model_addr(be, br, ie, ir, sc, d, sg);
                pb = model_bad(ie, ir, sc);
                have = 1;
            end
            @(negedge clk);
            in_valid = 1'b0;
            chk("R1 stream last", out_addr, pa);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule